// File: doc/BRIEF.md
# Padding-Aware Output Vectorizer

This block sits at the output of a convolution layer, after the pooling stage that comes before the next convolution. It takes pooled result rows, one lane-parallel vector per beat. It adds the zero border that the next layer's convolution needs. From each padded row it builds one pre-shifted copy per kernel column offset. Copy `k` is the padded row moved left by `k` positions. Each copy goes into a shift register of its own, one vector of PE width per entry.

When a preset number of rows (`GROUP`) has been gathered, the unit writes all stored copies to the feature-map buffer, one full-width word per cycle. While it does this, its input is held off. Because the padding and the column shifts are already in the stored words, the next layer can fetch any kernel column offset with a single aligned read. Every read returns a full vector.

The padding width, the kernel width and the count of valid values per row are runtime configuration inputs. They must stay stable while a group is being gathered and written.

Top module: `padvec`

## Requirements
- R1: After reset, and after any reset applied part-way through a group, `in_ready` is 1, `wr_en` is 0 and no partly gathered rows survive.
- R2: With `cfg_pad` = P > 0, lanes 0..P-1 of copy 0 are zero. Lanes P..P+N-1 hold the N valid input values (`cfg_len` = N, input lane 0 first), in input lane order.
- R3: Lane i of copy k equals lane i+k of the padded row (P zeros, then the N values, then zeros), for k from 0 to `cfg_kw`-1.
- R4: Every output lane at or beyond padded position N+2P holds zero. Input lanes at index N or above never reach the output, whatever they contain.
- R5: A row is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 1 until `GROUP` rows have been taken.
- R6: From the cycle after the `GROUP`-th row is taken, `wr_en` is 1 for exactly `cfg_kw`×`GROUP` cycles and `in_ready` is 0 during them. In the cycle after that, `in_ready` is 1 and `wr_en` is 0.
- R7: Words are written copy by copy (`wr_copy` 0 first). Within a copy the rows go oldest first (`wr_row` 0 is the first row taken). One word is written per cycle.
- R8: Only copies 0..`cfg_kw`-1 are written, for any `cfg_kw` from 1 to `MAXKW`.
- R9: `in_valid` asserted while `in_ready` is 0 has no effect. The held-off data appears in none of the later words.
- R10: With `cfg_pad` = 0, copy 0 equals the input in lanes 0..N-1 and is zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pad | input | $clog2(MAXP+1) | Zero border width P of the next layer |
| cfg_kw | input | $clog2(MAXKW+1) | Next kernel width, 1..MAXKW |
| cfg_len | input | $clog2(LANES+1) | Valid values per input row, 1..LANES |
| in_valid | input | 1 | Input row present |
| in_ready | output | 1 | Unit can take a row |
| in_data | input | LANES*DW | Pooled row, lane 0 in the low bits |
| wr_en | output | 1 | Buffer write strobe |
| wr_copy | output | $clog2(MAXKW) | Column offset k of the word being written |
| wr_row | output | $clog2(GROUP) | Row slot within the group, 0 = oldest |
| wr_data | output | LANES*DW | Packed, padded, shifted word |

## Verification
The shift-and-pad function is driven with a table of configurations. The table covers:
- a border of one around three values with a three-wide kernel, which tells apart correct padding from an off-by-one shift;
- a border of zero at full width, which isolates the shift from the padding;
- full-width rows with a border, so that the padded row runs past the lane count and shows that truncation keeps the low lanes;
- a single valid value under a two-wide border, which exposes stale upper lanes;
- kernel widths of one and two, which show whether the count of written copies follows the configuration.

Every input lane at or above the row length carries nonzero filler, so any leak shows up in the expected zeros. Data offered during write-out, and a reset in the middle of a group, separate correct flow control from words that absorb held-off or stale rows.

// File: rtl/padvec.sv
module padvec #(
  parameter int LANES = 16,
  parameter int DW    = 8,
  parameter int MAXP  = 2,
  parameter int MAXKW = 3,
  parameter int GROUP = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(MAXP+1)-1:0]     cfg_pad,
  input  logic [$clog2(MAXKW+1)-1:0]    cfg_kw,
  input  logic [$clog2(LANES+1)-1:0]    cfg_len,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LANES*DW-1:0]           in_data,
  output logic                          wr_en,
  output logic [$clog2(MAXKW)-1:0]      wr_copy,
  output logic [$clog2(GROUP)-1:0]      wr_row,
  output logic [LANES*DW-1:0]           wr_data
);
  localparam int VW = LANES * DW;
  localparam int CW = $clog2(MAXKW);
  localparam int RW = $clog2(GROUP);
  localparam logic [RW-1:0] LAST_ROW = RW'(GROUP - 1);

  logic [VW-1:0] shifted [MAXKW];
  logic [VW-1:0] sr [MAXKW][GROUP];
  logic [RW-1:0] acc_cnt;
  logic [RW-1:0] fr;
  logic [CW-1:0] fk;
  logic          flushing;
  logic          take;

  assign in_ready = !flushing;
  assign take     = in_valid && in_ready;
  assign wr_en    = flushing;
  assign wr_copy  = fk;
  assign wr_row   = fr;
  assign wr_data  = sr[fk][LAST_ROW - fr];

  always_comb begin
    for (int k = 0; k < MAXKW; k++) begin
      for (int i = 0; i < LANES; i++) begin
        int j;
        j = i + k - int'(cfg_pad);
        shifted[k][i*DW +: DW] = '0;
        if (j >= 0 && j < int'(cfg_len) && j < LANES)
          shifted[k][i*DW +: DW] = in_data[j*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < MAXKW; k++)
        for (int g = 0; g < GROUP; g++)
          sr[k][g] <= '0;
    end else if (take) begin
      for (int k = 0; k < MAXKW; k++) begin
        sr[k][0] <= shifted[k];
        for (int g = 1; g < GROUP; g++)
          sr[k][g] <= sr[k][g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt  <= '0;
      flushing <= 1'b0;
      fr       <= '0;
      fk       <= '0;
    end else if (flushing) begin
      if (fr == LAST_ROW) begin
        fr <= '0;
        if (32'(fk) + 32'd1 >= 32'(cfg_kw)) begin
          fk       <= '0;
          flushing <= 1'b0;
        end else begin
          fk <= fk + 1'b1;
        end
      end else begin
        fr <= fr + 1'b1;
      end
    end else if (take) begin
      if (acc_cnt == LAST_ROW) begin
        acc_cnt  <= '0;
        flushing <= 1'b1;
      end else begin
        acc_cnt <= acc_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/padvec_chk.sv
module padvec_chk #(
  parameter int LANES = 16,
  parameter int DW    = 8,
  parameter int MAXP  = 2,
  parameter int MAXKW = 3,
  parameter int GROUP = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [$clog2(MAXP+1)-1:0]  cfg_pad,
  input logic [$clog2(MAXKW+1)-1:0] cfg_kw,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       wr_en,
  input logic [$clog2(MAXKW)-1:0]   wr_copy,
  input logic [$clog2(GROUP)-1:0]   wr_row,
  input logic [LANES*DW-1:0]        wr_data
);
  localparam int RW = $clog2(GROUP);

  a_r1_idle_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !wr_en));

  a_r6_hold_off_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !in_ready);

  a_r6_write_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(in_valid && in_ready));

  a_r8_copy_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_copy) < 32'(cfg_kw)));

  a_r7_row_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && wr_row != '0) |-> (wr_row == RW'($past(wr_row) + 1'b1)));

  a_r2_left_border_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_copy == '0 && cfg_pad != '0) |-> (wr_data[DW-1:0] == '0));
endmodule

bind padvec padvec_chk #(
  .LANES(LANES), .DW(DW), .MAXP(MAXP), .MAXKW(MAXKW), .GROUP(GROUP)
) u_padvec_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pad(cfg_pad), .cfg_kw(cfg_kw),
  .in_valid(in_valid), .in_ready(in_ready), .wr_en(wr_en),
  .wr_copy(wr_copy), .wr_row(wr_row), .wr_data(wr_data)
);

// File: tb/test_padvec.sv
`timescale 1ns/1ps
module test_padvec;
  localparam int LANES = 16, DW = 8, MAXP = 2, MAXKW = 3, GROUP = 4;
  localparam int VW = LANES * DW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                          rst_n;
  logic [$clog2(MAXP+1)-1:0]     cfg_pad;
  logic [$clog2(MAXKW+1)-1:0]    cfg_kw;
  logic [$clog2(LANES+1)-1:0]    cfg_len;
  logic                          in_valid;
  logic                          in_ready;
  logic [VW-1:0]                 in_data;
  logic                          wr_en;
  logic [$clog2(MAXKW)-1:0]      wr_copy;
  logic [$clog2(GROUP)-1:0]      wr_row;
  logic [VW-1:0]                 wr_data;

  padvec #(.LANES(LANES), .DW(DW), .MAXP(MAXP), .MAXKW(MAXKW), .GROUP(GROUP)) i_padvec (
    .clk(clk), .rst_n(rst_n), .cfg_pad(cfg_pad), .cfg_kw(cfg_kw), .cfg_len(cfg_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wr_en(wr_en), .wr_copy(wr_copy), .wr_row(wr_row), .wr_data(wr_data)
  );

  // fields: pad[23:20] kw[19:16] len[15:8] seed[7:0]
  localparam logic [23:0] TBL [6] = '{
    {4'd1, 4'd3, 8'd3,  8'h10},
    {4'd0, 4'd1, 8'd16, 8'h20},
    {4'd2, 4'd3, 8'd12, 8'h40},
    {4'd1, 4'd2, 8'd16, 8'h60},
    {4'd2, 4'd3, 8'd1,  8'h80},
    {4'd0, 4'd3, 8'd5,  8'hA0}
  };

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] row_vec(input int seed, input int g);
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*DW +: DW] = DW'(seed + 16*g + i + 1);
    return v;
  endfunction

  function automatic logic [VW-1:0] exp_copy(input logic [VW-1:0] v, input int pad, input int len, input int k);
    logic [VW-1:0] r = '0;
    for (int i = 0; i < LANES; i++) begin
      int j = i + k - pad;
      if (j >= 0 && j < len) r[i*DW +: DW] = v[j*DW +: DW];
    end
    return r;
  endfunction

  task automatic run_group(input int pad, input int kw, input int len, input int seed, input bit junk);
    string req;
    cfg_pad = 2'(pad); cfg_kw = 2'(kw); cfg_len = 5'(len);
    for (int g = 0; g < GROUP; g++) begin
      in_valid = 1'b1;
      in_data  = row_vec(seed, g);
      chk(in_ready == 1'b1 && wr_en == 1'b0, "R5 ready while gathering", VW'(in_ready), VW'(1));
      @(negedge clk);
    end
    in_valid = junk;
    in_data  = '1;
    for (int c = 0; c < kw; c++) begin
      for (int r = 0; r < GROUP; r++) begin
        chk(wr_en == 1'b1 && in_ready == 1'b0, "R6 write window", VW'({wr_en, in_ready}), VW'(2'b10));
        chk(int'(wr_copy) == c && int'(wr_row) == r, "R7 order", VW'({wr_copy, wr_row}), VW'(c*4 + r));
        req = (pad == 0) ? "R10 no border" : (c == 0 ? "R2 border" : "R3 shifted copy");
        chk(wr_data == exp_copy(row_vec(seed, r), pad, len, c), req, wr_data, exp_copy(row_vec(seed, r), pad, len, c));
        if (c == 0 && len + 2*pad < LANES)
          chk((wr_data >> ((len + 2*pad)*DW)) == '0, "R4 upper lanes zero", wr_data >> ((len + 2*pad)*DW), '0);
        if (c == kw - 1 && r == GROUP - 1) in_valid = 1'b0;
        @(negedge clk);
      end
    end
    chk(wr_en == 1'b0 && in_ready == 1'b1, "R8 stops after kw copies", VW'({wr_en, in_ready}), VW'(2'b01));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    cfg_pad = '0; cfg_kw = 2'd1; cfg_len = 5'd16;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && wr_en == 1'b0, "R1 reset state", VW'({in_ready, wr_en}), VW'(2'b10));
    rst_n = 1'b1;
    @(negedge clk);

    for (int t = 0; t < 6; t++)
      run_group(int'(TBL[t][23:20]), int'(TBL[t][19:16]), int'(TBL[t][15:8]), int'(TBL[t][7:0]), t[0]);

    // R9: offer data throughout the write window, then check the next group is clean
    run_group(1, 3, 3, 8'h33, 1'b1);
    run_group(1, 3, 3, 8'h55, 1'b0);

    // R1: reset part-way through a group drops the partial rows
    cfg_pad = 2'd1; cfg_kw = 2'd2; cfg_len = 5'd4;
    for (int g = 0; g < 2; g++) begin
      in_valid = 1'b1; in_data = row_vec(8'hEE, g);
      @(negedge clk);
    end
    in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(in_ready == 1'b1 && wr_en == 1'b0, "R1 reset mid group", VW'({in_ready, wr_en}), VW'(2'b10));
    @(negedge clk);
    run_group(1, 2, 4, 8'h07, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule